// File: doc/BRIEF.md
# Block-Read Controller for a Multiplexed-Address DRAM

This controller fetches one cache block from a DRAM array whose row and column addresses share one address bus. A cache-side port hands it a block request carrying a word address, using a valid/ready handshake. The controller opens the row by driving the row half of the address with a row strobe. It then steps through the block's columns with a column strobe. It samples the DRAM data bus once per beat and returns each beat with a valid flag and a last-beat flag.

Beat timing is set by a style parameter that yields a first-beat latency and a per-beat gap. A page-mode style gives 5-3-3-3 cycles, an extended-data-out style gives 5-2-2-2 cycles and a synchronous style gives 4-1-1-1 cycles. A free-running timer requests a row refresh at a fixed cycle interval. The controller serves each refresh between block reads. A refresh drives a row strobe on its own, carries a row taken from an internal counter, and never asserts the column strobe.

Top module: `blkrd_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `row_strobe`, `col_strobe`, `rsp_valid` and `rsp_last` are 0, with `mem_addr` equal to 0.
- R2: In the cycle after a request is accepted, `row_strobe` is 1, `col_strobe` is 0 and `mem_addr` carries the row, which is `req_addr[21:11]`. From the next cycle `col_strobe` is 1, and `row_strobe` stays 1 until the last beat has been sampled.
- R3: Counting the cycle after the accepting clock edge as cycle 1, beat k (k = 0..3) is presented with `rsp_valid` = 1 in cycle FIRST + k*NEXT. With the default extended-data-out style this gives 5-2-2-2, so the last beat arrives in cycle 11.
- R4: Beat k returns the value on `mem_rdata` while `mem_addr` carries the column {`req_addr[10:2]`, k}. Beats come in ascending k, and the two low column bits of the request have no effect.
- R5: `rsp_last` is 1 together with the fourth `rsp_valid` pulse and is 0 in every other cycle.
- R6: Between two beats of a block, `rsp_data` holds the previous beat while the next column address is on the bus.
- R7: `req_ready` is 0 from the cycle after acceptance until the last-beat cycle.
- R8: A refresh tick occurs in every cycle whose count c of clock edges since reset satisfies c mod REF_INTERVAL = REF_INTERVAL-1. In a tick cycle `req_ready` is 0, so a refresh wins over a read that arrives in the same cycle.
- R9: A refresh that becomes due during a block read waits until that read's last beat. It starts in a cycle with no read outstanding.
- R10: A refresh holds `row_strobe` = 1 and `col_strobe` = 0 for REF_CYCLES cycles, with `mem_addr` carrying the refresh row. The refresh row starts at 0 after reset and increments after each refresh, wrapping from 2047 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Block request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | 22 | Word address: row in [21:11], column in [10:0] |
| row_strobe | output | 1 | Row strobe, active high |
| col_strobe | output | 1 | Column strobe, active high |
| mem_addr | output | 11 | Shared row/column address bus |
| mem_rdata | input | 64 | DRAM data bus |
| rsp_valid | output | 1 | Beat valid |
| rsp_data | output | 64 | Beat data |
| rsp_last | output | 1 | Fourth beat of the block |

## Verification
A refresh tick and a new block request can land in the same cycle. The bench provokes this by counting clock edges from reset and raising `req_valid` exactly in a tick cycle. It then judges that `req_ready` stays low there. It also checks that the next row opening is a refresh carrying the expected counter row, and that the held request is served after it with correct beat timing. A second case raises a request a few cycles before a tick, so the tick falls inside the read. That case checks that no refresh starts before the fourth beat.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_COL  = 2'd2,
        PH_REF  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        STY_FPM  = 2'd0,
        STY_EDO  = 2'd1,
        STY_SYNC = 2'd2
    } style_e;

    // Cycles from acceptance to the first beat for a timing style.
    function automatic int unsigned lead_cycles(style_e s);
        case (s)
            STY_FPM:  return 5;
            STY_EDO:  return 5;
            STY_SYNC: return 4;
            default:  return 5;
        endcase
    endfunction

    // Cycles between consecutive beats for a timing style.
    function automatic int unsigned gap_cycles(style_e s);
        case (s)
            STY_FPM:  return 3;
            STY_EDO:  return 2;
            STY_SYNC: return 1;
            default:  return 3;
        endcase
    endfunction

endpackage

// File: rtl/blkrd_ref_timer.sv
module blkrd_ref_timer #(
    parameter int unsigned INTERVAL = 520
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [TW-1:0] tmr_q;

    assign tick = (tmr_q == TW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst)       tmr_q <= '0;
        else if (tick) tmr_q <= '0;
        else           tmr_q <= tmr_q + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R8

endmodule

// File: rtl/blkrd_beat_timer.sv
module blkrd_beat_timer #(
    parameter int unsigned FIRST = 5,
    parameter int unsigned NEXT  = 2,
    parameter int unsigned BEATS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic                       run,
    output logic                       take,
    output logic [$clog2(BEATS)-1:0]   beat,
    output logic                       final_beat
);
    localparam int unsigned BW    = $clog2(BEATS);
    localparam int unsigned TOTAL = FIRST + (BEATS - 1) * NEXT;
    localparam int unsigned CW    = $clog2(TOTAL + NEXT + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] due_q;
    logic [BW-1:0] beat_q;

    // Sample at the edge closing the cycle before the beat is due.
    assign take       = run && (cnt_q == due_q - 1'b1);
    assign beat       = beat_q;
    assign final_beat = take && (beat_q == BW'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            due_q  <= '0;
            beat_q <= '0;
        end else if (start) begin
            cnt_q  <= CW'(1);
            due_q  <= CW'(FIRST);
            beat_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
            if (take) begin
                beat_q <= beat_q + 1'b1;
                due_q  <= due_q + CW'(NEXT);
            end
        end
    end

    AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (take && !final_beat) |=> (beat_q == $past(beat_q) + 1'b1)); // R4

endmodule

// File: rtl/blkrd_addr_mux.sv
module blkrd_addr_mux #(
    parameter int unsigned AW = 11,
    parameter int unsigned BW = 2
) (
    input  blkrd_pkg::phase_e phase,
    input  logic [AW-1:0]     row,
    input  logic [AW-1:0]     ref_row,
    input  logic [AW-BW-1:0]  chi,
    input  logic [BW-1:0]     beat,
    output logic [AW-1:0]     addr
);
    always_comb begin
        case (phase)
            blkrd_pkg::PH_ROW: addr = row;
            blkrd_pkg::PH_COL: addr = {chi, beat};
            blkrd_pkg::PH_REF: addr = ref_row;
            default:           addr = '0;
        endcase
    end
endmodule

// File: rtl/blkrd_ctrl.sv
module blkrd_ctrl
    import blkrd_pkg::*;
#(
    parameter style_e      STYLE        = STY_EDO,
    parameter int unsigned AW           = 11,
    parameter int unsigned DW           = 64,
    parameter int unsigned BEATS        = 4,
    parameter int unsigned REF_INTERVAL = 520,
    parameter int unsigned REF_CYCLES   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [2*AW-1:0] req_addr,
    output logic            row_strobe,
    output logic            col_strobe,
    output logic [AW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic            rsp_last
);
    localparam int unsigned FIRST = lead_cycles(STYLE);
    localparam int unsigned NEXT  = gap_cycles(STYLE);
    localparam int unsigned BW    = $clog2(BEATS);
    localparam int unsigned RCW   = (REF_CYCLES > 1) ? $clog2(REF_CYCLES) : 1;

    typedef struct packed {
        logic [AW-1:0]    row;
        logic [AW-BW-1:0] chi;
    } blk_req_t;

    phase_e         phase_q, phase_d;
    blk_req_t       req_q;
    logic [AW-1:0]  ref_row_q;
    logic [RCW-1:0] ref_cnt_q;
    logic           ref_pend_q;
    logic           rsp_valid_q, rsp_last_q;
    logic [DW-1:0]  rsp_data_q;

    logic           tick, take, fin, run;
    logic [BW-1:0]  beat;
    logic           pend_now, accept, go_ref, ref_done;
    logic           ign_unused;

    assign ign_unused = ^req_addr[BW-1:0];

    blkrd_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign run = (phase_q == PH_ROW) || (phase_q == PH_COL);

    blkrd_beat_timer #(.FIRST(FIRST), .NEXT(NEXT), .BEATS(BEATS)) u_beats (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .run        (run),
        .take       (take),
        .beat       (beat),
        .final_beat (fin)
    );

    blkrd_addr_mux #(.AW(AW), .BW(BW)) u_amux (
        .phase   (phase_q),
        .row     (req_q.row),
        .ref_row (ref_row_q),
        .chi     (req_q.chi),
        .beat    (beat),
        .addr    (mem_addr)
    );

    // A pending or just-arriving refresh blocks new reads.
    assign pend_now  = ref_pend_q | tick;
    assign req_ready = (phase_q == PH_IDLE) && !pend_now;
    assign accept    = req_valid && req_ready;
    assign go_ref    = (phase_q == PH_IDLE) && pend_now;
    assign ref_done  = (phase_q == PH_REF) && (ref_cnt_q == RCW'(REF_CYCLES - 1));

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: begin
                if (go_ref)      phase_d = PH_REF;
                else if (accept) phase_d = PH_ROW;
            end
            PH_ROW:  phase_d = PH_COL;
            PH_COL:  if (fin)      phase_d = PH_IDLE;
            PH_REF:  if (ref_done) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            req_q       <= '0;
            ref_row_q   <= '0;
            ref_cnt_q   <= '0;
            ref_pend_q  <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_last_q  <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            phase_q <= phase_d;
            if (accept)
                req_q <= '{row: req_addr[2*AW-1:AW], chi: req_addr[AW-1:BW]};
            ref_pend_q <= go_ref ? 1'b0 : pend_now;
            if (go_ref)                 ref_cnt_q <= '0;
            else if (phase_q == PH_REF) ref_cnt_q <= ref_cnt_q + 1'b1;
            if (ref_done) ref_row_q <= ref_row_q + 1'b1;
            rsp_valid_q <= take;
            rsp_last_q  <= fin;
            if (take) rsp_data_q <= mem_rdata;
        end
    end

    assign row_strobe = (phase_q != PH_IDLE);
    assign col_strobe = (phase_q == PH_COL);
    assign rsp_valid  = rsp_valid_q;
    assign rsp_data   = rsp_data_q;
    assign rsp_last   = rsp_last_q;

    AST_ROW_FIRST: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            (row_strobe && !col_strobe && mem_addr == $past(req_addr[2*AW-1:AW]))); // R2

    AST_COL_AFTER_ROW: assert property (@(posedge clk) disable iff (rst)
        $rose(col_strobe) |-> $past(row_strobe)); // R2

    AST_LAST_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid); // R5

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> $stable(rsp_data)); // R6

    AST_REF_WINS: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && pend_now) |=> (phase_q == PH_REF)); // R8

    AST_REF_STEP: assert property (@(posedge clk) disable iff (rst)
        ref_done |=> (ref_row_q == $past(ref_row_q) + 1'b1)); // R10

endmodule

// File: tb/blkrd_ctrl_test.sv
module blkrd_ctrl_test;
    localparam int AW    = 11;
    localparam int DW    = 64;
    localparam int BEATS = 4;
    localparam int INTV  = 40;
    localparam int RC    = 3;
    localparam int FIRST = 5;
    localparam int NEXT  = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [2*AW-1:0] req_addr = '0;
    logic            row_strobe, col_strobe;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_rdata;
    logic            rsp_valid, rsp_last;
    logic [DW-1:0]   rsp_data;

    always #5 clk = ~clk;

    blkrd_ctrl #(
        .STYLE(blkrd_pkg::STY_EDO), .AW(AW), .DW(DW), .BEATS(BEATS),
        .REF_INTERVAL(INTV), .REF_CYCLES(RC)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .row_strobe(row_strobe), .col_strobe(col_strobe),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_last(rsp_last)
    );

    // DRAM model: latches the row on a row-only cycle, returns a word built
    // from the open row and the column on the bus.
    logic [AW-1:0] dram_row = '0;
    always @(posedge clk) if (row_strobe && !col_strobe) dram_row <= mem_addr;
    assign mem_rdata = {21'd0, dram_row, mem_addr, 21'h1B5A3};

    int cyc;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    typedef struct {
        logic [DW-1:0] data;
        logic          last;
        int            when;
    } beat_t;
    beat_t exp_q[$];

    int checks = 0;
    int errors = 0;
    int acc_cyc = -1000;
    logic [AW-1:0] last_row = '0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Driver: called at a negedge; waits for acceptance and pushes beats.
    task automatic issue(input logic [AW-1:0] r, input logic [AW-1:0] c);
        req_valid = 1'b1;
        req_addr  = {r, c};
        while (!req_ready) @(negedge clk);
        acc_cyc  = cyc + 1;
        last_row = r;
        for (int k = 0; k < BEATS; k++) begin
            beat_t b;
            b.data = {21'd0, r, c[AW-1:2], 2'(k), 21'h1B5A3};
            b.last = (k == BEATS - 1);
            b.when = acc_cyc + FIRST + k * NEXT - 1;
            exp_q.push_back(b);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor
    logic          prev_rs = 1'b0;
    bit            opening = 0;
    logic [AW-1:0] open_addr;
    logic [AW-1:0] exp_ref = '0;
    int            ref_seen = 0;
    bit            wrap_seen = 0;
    logic [DW-1:0] last_data = '0;
    bit            seen_any = 0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            beat_t e;
            if (exp_q.size() > 0 && cyc >= acc_cyc && !(rsp_valid && rsp_last)) begin
                chk(!req_ready, "R7", "ready during read", 64'(req_ready), 64'(0));
                chk(row_strobe, "R2", "row strobe held", 64'(row_strobe), 64'(1));
            end
            if (cyc % INTV == INTV - 1)
                chk(!req_ready, "R8", "ready in tick cycle", 64'(req_ready), 64'(0));
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected beat", 64'(cyc), 64'(0));
                end else begin
                    e = exp_q.pop_front();
                    chk(rsp_data == e.data, "R4", "beat data", rsp_data, e.data);
                    chk(rsp_last == e.last, "R5", "last flag", 64'(rsp_last), 64'(e.last));
                    chk(cyc == e.when, "R3", "beat cycle", 64'(cyc), 64'(e.when));
                end
                last_data = rsp_data;
                seen_any  = 1;
            end else if (exp_q.size() > 0) begin
                chk(!rsp_last, "R5", "last without valid", 64'(rsp_last), 64'(0));
                if (seen_any && exp_q.size() < BEATS)
                    chk(rsp_data == last_data, "R6", "data hold", rsp_data, last_data);
                if (cyc > exp_q[0].when) begin
                    chk(0, "R3", "missing beat", 64'(cyc), 64'(exp_q[0].when));
                    void'(exp_q.pop_front());
                end
            end
            if (opening) begin
                opening = 0;
                if (col_strobe) begin
                    chk(open_addr == last_row, "R2", "row address", 64'(open_addr), 64'(last_row));
                end else begin
                    chk(open_addr == exp_ref, "R10", "refresh row", 64'(open_addr), 64'(exp_ref));
                    chk(exp_q.size() == 0, "R9", "refresh during read",
                        64'(exp_q.size()), 64'(0));
                    if (open_addr == '0 && ref_seen > 0) wrap_seen = 1;
                    exp_ref = open_addr + 1'b1;
                    ref_seen++;
                end
            end
            if (row_strobe && !col_strobe && !prev_rs) begin
                opening   = 1;
                open_addr = mem_addr;
            end
            prev_rs = row_strobe;
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready", 64'(req_ready), 64'(1));
        chk(!row_strobe, "R1", "row strobe", 64'(row_strobe), 64'(0));
        chk(!col_strobe, "R1", "col strobe", 64'(col_strobe), 64'(0));
        chk(!rsp_valid, "R1", "valid", 64'(rsp_valid), 64'(0));
        chk(!rsp_last, "R1", "last", 64'(rsp_last), 64'(0));
        chk(mem_addr == '0, "R1", "address", 64'(mem_addr), 64'(0));
        @(negedge clk);

        issue(11'h005, 11'h040);
        issue(11'h7FF, 11'h7FC);          // top row and top block
        issue(11'h123, 11'h2A7);          // low column bits set (R4)
        issue(11'h000, 11'h003);
        for (int i = 0; i < 3; i++)       // back to back
            issue(11'(16 * i + 7), 11'(64 * i + 8));
        while (exp_q.size() > 0) @(negedge clk);

        // R8: request raised exactly in a tick cycle
        while (cyc % INTV != INTV - 1) @(negedge clk);
        issue(11'h2AA, 11'h154);
        while (exp_q.size() > 0) @(negedge clk);

        // R9: tick falls inside a read
        while (cyc % INTV != INTV - 5) @(negedge clk);
        issue(11'h3C3, 11'h0F0);
        while (exp_q.size() > 0) @(negedge clk);

        // R10: idle long enough for the refresh row to wrap
        repeat (2048 * INTV + 2 * INTV) @(negedge clk);
        chk(wrap_seen, "R10", "refresh row wrap", 64'(wrap_seen), 64'(1));
        chk(ref_seen >= cyc / INTV - 1, "R8", "refresh count",
            64'(ref_seen), 64'(cyc / INTV - 1));
        finish_run();
    end

endmodule